// File: doc/BRIEF.md
# Bit-Serial Reflected CRC-32 Engine

This block keeps a 32-bit CRC remainder in the reflected (LSB-first) convention, with polynomial constant 0xEDB88320. It takes one byte at a time over a valid/ready handshake. When a byte is accepted, it is folded into the low eight bits of the remainder. The remainder then advances one shift step per clock, so a byte takes eight clock cycles. Each cycle's logic depth is a single conditional XOR, and there is no long combinational chain.

The consumer starts a message with a one-cycle start pulse. The pulse loads the remainder either with the all-ones value or with a caller-supplied seed. Loading a seed taken from an earlier `crc_out` lets a long message be fed in any number of separate segments, and the result is the same as for one continuous stream. The output is the raw remainder. Any final complement is applied outside the block.

`busy` shows that shift steps are still pending. `done` shows that `crc_out` holds the settled value after the most recent byte.

Top module: `crc32_ser_engine`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to idle. After that edge, `crc_out` = 0xFFFFFFFF, `in_ready` = 1, `busy` = 0 and `done` = 0.
- R2: A byte is accepted at a clock edge where `in_valid` and `in_ready` are both 1. At that edge `in_data` is XORed into bits 7:0 of the remainder, and the first shift step is applied. A step maps r to (r >> 1) XOR 0xEDB88320 when bit 0 of r is 1, and to r >> 1 otherwise.
- R3: Each accepted byte gets exactly eight shift steps, one per clock. `in_ready` is 0 for the seven cycles after the accepting edge and is 1 again in the cycle after the eighth step.
- R4: `busy` is 1 exactly while shift steps for an accepted byte remain.
- R5: `done` becomes 1 in the cycle after the eighth step of a byte. It stays 1 until the next accepted byte or start.
- R6: A `start` pulse while idle loads the remainder from `seed` when `use_seed` = 1, or with 0xFFFFFFFF when `use_seed` = 0. It also clears `done`.
- R7: `start` wins over `in_valid`: `in_ready` is 0 in any cycle where `start` is 1, so no byte is taken. A `start` that arrives while `busy` is 1 has no effect.
- R8: A message fed as one segment, then restarted with `seed` equal to that segment's final `crc_out` and fed the rest, ends with the same `crc_out` as the whole message fed as one stream.
- R9: No final complement is applied. The nine ASCII bytes "123456789", fed from the all-ones start, leave `crc_out` = 0x340BC6D9, and its bitwise inverse is 0xCBF43926.
- R10: In an idle cycle where `in_valid` and `start` are both 0, the remainder does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that loads the remainder |
| use_seed | input | 1 | 1: load from `seed`; 0: load all ones |
| seed | input | 32 | Caller-supplied starting remainder |
| in_valid | input | 1 | `in_data` holds a byte to absorb |
| in_data | input | 8 | Message byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| crc_out | output | 32 | Current raw remainder |
| busy | output | 1 | Shift steps still pending |
| done | output | 1 | Remainder settled after the last byte |

## Verification
The assertions assume four things about the inputs:
- `seed` and `use_seed` are valid in the cycle `start` is high.
- `in_data` is valid whenever `in_valid` is high.
- `rst` is asserted from time zero.
- `start` is a pulse and not a level.

The stimulus drives every input just after the falling edge. It raises `start` for exactly one cycle, and it offers a byte only after seeing `in_ready` high. Some cases deliberately break the normal flow: `start` is raised while shifting, and `start` and `in_valid` are raised together. Both stay legal input patterns, because the block defines its response to each of them.

// File: rtl/crc32_ser_pkg.sv
package crc32_ser_pkg;

    localparam int CRC_W = 32;

    typedef logic [CRC_W-1:0] crc_t;

    localparam crc_t POLY_REFLECTED = 32'hEDB88320;
    localparam crc_t REM_ALL_ONES   = 32'hFFFFFFFF;

    // Operation the remainder register performs at the next edge
    typedef enum logic [1:0] {
        OP_HOLD,
        OP_LOAD,
        OP_ABSORB,
        OP_SHIFT
    } rem_op_e;

    typedef enum logic {
        ST_IDLE,
        ST_SHIFT
    } ctl_state_e;

    // One reflected division step
    function automatic crc_t crc_shift1(crc_t r, crc_t poly);
        crc_t shifted;
        shifted = r >> 1;
        if (r[0]) begin
            return shifted ^ poly;
        end
        return shifted;
    endfunction

endpackage

// File: rtl/crc32_ser_ctrl.sv
module crc32_ser_ctrl
    import crc32_ser_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    in_valid,
    output logic    in_ready,
    output logic    busy,
    output logic    done,
    output rem_op_e op
);

    localparam int CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] STEPS_AFTER_FIRST = CNT_W'(BYTE_W - 1);

    ctl_state_e       state;
    logic [CNT_W-1:0] remain;
    logic             is_idle;
    logic             accept;
    logic             load;

    always_comb begin
        is_idle  = (state == ST_IDLE);
        load     = is_idle && start;
        in_ready = is_idle && !start;
        accept   = in_ready && in_valid;
        busy     = (state == ST_SHIFT);
        if (load) begin
            op = OP_LOAD;
        end else if (accept) begin
            op = OP_ABSORB;
        end else if (busy) begin
            op = OP_SHIFT;
        end else begin
            op = OP_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            remain <= '0;
            done   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (load) begin
                        done <= 1'b0;
                    end else if (accept) begin
                        state  <= ST_SHIFT;
                        remain <= STEPS_AFTER_FIRST;
                        done   <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    remain <= remain - 1'b1;
                    if (remain == CNT_W'(1)) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3
    accept_then_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> busy);

    // R5
    done_after_shift_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy));

    // R7
    start_blocks_ready_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !in_ready);

endmodule

// File: rtl/crc32_ser_datapath.sv
module crc32_ser_datapath
    import crc32_ser_pkg::*;
#(
    parameter int   BYTE_W = 8,
    parameter crc_t POLY   = POLY_REFLECTED,
    parameter crc_t INIT   = REM_ALL_ONES
) (
    input  logic              clk,
    input  logic              rst,
    input  rem_op_e           op,
    input  logic              use_seed,
    input  crc_t              seed,
    input  logic [BYTE_W-1:0] data,
    output crc_t              rem
);

    localparam int PAD_W = CRC_W - BYTE_W;

    crc_t absorbed;
    crc_t load_val;

    always_comb begin
        absorbed = rem ^ {{PAD_W{1'b0}}, data};
        load_val = use_seed ? seed : INIT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= INIT;
        end else begin
            case (op)
                OP_LOAD:   rem <= load_val;
                OP_ABSORB: rem <= crc_shift1(absorbed, POLY);
                OP_SHIFT:  rem <= crc_shift1(rem, POLY);
                default:   rem <= rem;
            endcase
        end
    end

    // R10
    hold_keeps_rem_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD) |=> $stable(rem));

endmodule

// File: rtl/crc32_ser_engine.sv
module crc32_ser_engine
    import crc32_ser_pkg::*;
#(
    parameter int   BYTE_W = 8,
    parameter crc_t POLY   = POLY_REFLECTED,
    parameter crc_t INIT   = REM_ALL_ONES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              use_seed,
    input  logic [31:0]       seed,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic [31:0]       crc_out,
    output logic              busy,
    output logic              done
);

    rem_op_e op;

    crc32_ser_ctrl #(
        .BYTE_W (BYTE_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .busy     (busy),
        .done     (done),
        .op       (op)
    );

    crc32_ser_datapath #(
        .BYTE_W (BYTE_W),
        .POLY   (POLY),
        .INIT   (INIT)
    ) u_dp (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .use_seed (use_seed),
        .seed     (seed),
        .data     (in_data),
        .rem      (crc_out)
    );

    // R6
    start_all_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !use_seed) |=> (crc_out == INIT));

    // R6
    start_seed_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && use_seed) |=> (crc_out == $past(seed)));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> $stable(crc_out));

endmodule

// File: tb/crc32_ser_engine_bench.sv
`timescale 1ns/1ps
module crc32_ser_engine_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        use_seed = 1'b0;
    logic [31:0] seed = 32'h0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h0;
    logic        in_ready;
    logic [31:0] crc_out;
    logic        busy;
    logic        done;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    crc32_ser_engine u_crc32_ser_engine (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .use_seed (use_seed),
        .seed     (seed),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .crc_out  (crc_out),
        .busy     (busy),
        .done     (done)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0] m_rem  = 32'hFFFFFFFF;
    int          m_left = 0;
    bit          m_done = 1'b0;
    bit          m_live = 1'b0;

    function automatic logic [31:0] ref_step(input logic [31:0] r);
        if (r[0] == 1'b1) return (r >> 1) ^ 32'hEDB88320;
        return r >> 1;
    endfunction

    always @(posedge clk) begin
        m_live = 1'b1;
        if (rst) begin
            m_rem = 32'hFFFFFFFF;
            m_left = 0;
            m_done = 1'b0;
        end else if (m_left > 0) begin
            m_rem = ref_step(m_rem);
            m_left = m_left - 1;
            if (m_left == 0) m_done = 1'b1;
        end else if (start) begin
            m_rem = use_seed ? seed : 32'hFFFFFFFF;
            m_done = 1'b0;
        end else if (in_valid) begin
            m_rem = ref_step(m_rem ^ {24'h0, in_data});
            m_left = 7;
            m_done = 1'b0;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (m_live) begin
            chk("R2", "crc_out", crc_out, m_rem);
            chk("R3", "in_ready", {31'h0, in_ready},
                {31'h0, (m_left == 0) && !start});
            chk("R4", "busy", {31'h0, busy}, {31'h0, m_left != 0});
            chk("R5", "done", {31'h0, done}, {31'h0, m_done});
        end
        if (cyc > 50000) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 50000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); #1;
        while (!in_ready) begin
            @(negedge clk); #1;
        end
        in_valid = 1'b1;
        in_data  = b;
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) send_byte(s[i]);
        wait_idle();
    endtask

    task automatic do_start(input logic us, input logic [31:0] sv);
        @(negedge clk); #1;
        start = 1'b1;
        use_seed = us;
        seed = sv;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    logic [31:0] mid;
    logic [31:0] held;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "crc_out after reset", crc_out, 32'hFFFFFFFF);
        chk("R1", "in_ready after reset", {31'h0, in_ready}, 32'h1);
        chk("R1", "busy after reset", {31'h0, busy}, 32'h0);
        chk("R1", "done after reset", {31'h0, done}, 32'h0);

        // R9 known answer, raw remainder
        do_start(1'b0, 32'h0);
        send_str("123456789");
        chk("R9", "check value raw", crc_out, 32'h340BC6D9);
        chk("R9", "check value inverted", ~crc_out, 32'hCBF43926);
        chk("R5", "done after last byte", {31'h0, done}, 32'h1);

        // R10 idle hold
        held = crc_out;
        repeat (5) @(negedge clk);
        chk("R10", "idle remainder", crc_out, held);

        // R8 chaining across segments
        do_start(1'b0, 32'hDEADBEEF);
        send_str("1234");
        mid = crc_out;
        do_start(1'b1, mid);
        chk("R6", "seed loaded", crc_out, mid);
        chk("R5", "done cleared by start", {31'h0, done}, 32'h0);
        send_str("56789");
        chk("R8", "chained result", crc_out, 32'h340BC6D9);

        // R6 use_seed low ignores seed value
        do_start(1'b0, 32'h12345678);
        chk("R6", "all-ones load", crc_out, 32'hFFFFFFFF);
        do_start(1'b1, 32'h12345678);
        chk("R6", "explicit seed load", crc_out, 32'h12345678);

        // R3 in_ready low for seven cycles after acceptance
        begin
            int low = 0;
            send_byte(8'hA5);
            @(negedge clk);
            while (!in_ready) begin
                low++;
                @(negedge clk);
            end
            chk("R3", "ready-low cycles", low, 7);
        end

        // R7 start while busy is ignored
        send_byte(8'h3C);
        do_start(1'b1, 32'h0BADF00D);
        wait_idle();
        chk("R7", "start during shift ignored", crc_out, m_rem);
        chk("R7", "not seeded while busy", {31'h0, crc_out == 32'h0BADF00D}, 32'h0);

        // R7 start and in_valid together: start wins, byte not taken
        @(negedge clk); #1;
        start = 1'b1; use_seed = 1'b1; seed = 32'h55AA55AA;
        in_valid = 1'b1; in_data = 8'hFF;
        @(posedge clk); #1;
        start = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        chk("R7", "start beats valid", crc_out, 32'h55AA55AA);
        chk("R7", "no shift after start", {31'h0, busy}, 32'h0);

        // back-to-back bytes, patterned data
        do_start(1'b0, 32'h0);
        for (int i = 0; i < 16; i++) send_byte(8'(i * 37 + 1));
        wait_idle();
        chk("R2", "patterned stream", crc_out, m_rem);

        // R1 reset in mid-shift
        send_byte(8'h81);
        @(negedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset mid-shift crc", crc_out, 32'hFFFFFFFF);
        chk("R1", "reset mid-shift busy", {31'h0, busy}, 32'h0);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule